// File: doc/BRIEF.md
# Fetch-to-Decode Pipeline Register

This block is the stage register between instruction fetch and instruction decode in a 32-bit in-order pipeline. It registers the fetched program counter and instruction word on each rising clock edge and presents them to decode. Two control inputs set what each edge captures. `stall_i` freezes the instruction slot and zeroes the PC slot. `flush_i` empties the instruction slot after a taken redirect while the PC still advances.

An all-zero instruction word is the no-operation bubble that downstream logic expects, and it is the only bubble encoding this register ever produces. Hazard logic outside the block decides when to stall or flush. The register only applies those decisions, with stall taking priority.

Top module: `fd_pipe_reg`

## Requirements
- R1: While `rst_ni` is low, both `pc_o` and `instr_o` are 32'h0. The reset acts at once, without waiting for a clock edge, and it overrides `stall_i` and `flush_i`.
- R2: On an edge where `stall_i` is 1, `pc_o` loads 32'h0.
- R3: On an edge where `stall_i` is 1, `instr_o` keeps its previous value. Over several stall edges in a row it stays stable.
- R4: Stall has priority over flush. On an edge where both are 1, `instr_o` is held and `pc_o` loads 32'h0.
- R5: On an edge where `stall_i` is 0, `pc_o` loads `pc_i`, whatever the value of `flush_i`.
- R6: On an edge where `stall_i` is 0 and `flush_i` is 1, `instr_o` loads 32'h0, which is the bubble encoding.
- R7: On an edge where both `stall_i` and `flush_i` are 0, `instr_o` loads `instr_i`. This includes the first edge after a flush.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stall_i | input | 1 | Hold the instruction and zero the PC this edge |
| flush_i | input | 1 | Load a bubble instruction this edge (ignored while stalled) |
| pc_i | input | 32 | Program counter from fetch |
| instr_i | input | 32 | Instruction word from fetch |
| pc_o | output | 32 | Registered program counter to decode |
| instr_o | output | 32 | Registered instruction word to decode |

## Verification
Stall and flush can both be asserted on the same edge, and that collision decides whether the held instruction survives. The bench sweeps every sequence of three consecutive stall/flush combinations, so each pairing occurs with each neighbour. This covers stall with flush, stall after stall, and capture right after flush. Every edge's fetch data is a fresh arithmetic pattern, so a held word and a newly loaded word always differ. After each edge both outputs are compared with a model built from the update rules. Reset is also asserted in mid-run with stall and flush both high.

// File: rtl/fd_pkg.sv
package fd_pkg;
  typedef enum logic [1:0] {
    SEL_LOAD = 2'd0,
    SEL_ZERO = 2'd1,
    SEL_HOLD = 2'd2
  } slot_sel_e;
endpackage

// File: rtl/fd_ctrl.sv
module fd_ctrl
  import fd_pkg::*;
(
  input  logic      stall_i,
  input  logic      flush_i,
  output slot_sel_e pc_sel_o,
  output slot_sel_e ins_sel_o
);
  // stall wins over flush
  always_comb begin
    if (stall_i) begin
      pc_sel_o  = SEL_ZERO;
      ins_sel_o = SEL_HOLD;
    end else begin
      pc_sel_o  = SEL_LOAD;
      ins_sel_o = flush_i ? SEL_ZERO : SEL_LOAD;
    end
  end
endmodule

// File: rtl/fd_slot.sv
module fd_slot
  import fd_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  slot_sel_e        sel_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] q_q;
  logic [WIDTH-1:0] q_d;

  always_comb begin
    unique case (sel_i)
      SEL_LOAD: q_d = d_i;
      SEL_ZERO: q_d = '0;
      default:  q_d = q_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= q_d;
  end

  assign q_o = q_q;
endmodule

// File: rtl/fd_pipe_reg.sv
module fd_pipe_reg
  import fd_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            stall_i,
  input  logic            flush_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] instr_i,
  output logic [XLEN-1:0] pc_o,
  output logic [XLEN-1:0] instr_o
);
  slot_sel_e pc_sel;
  slot_sel_e ins_sel;

  fd_ctrl u_ctrl (
    .stall_i  (stall_i),
    .flush_i  (flush_i),
    .pc_sel_o (pc_sel),
    .ins_sel_o(ins_sel)
  );

  fd_slot #(.WIDTH(XLEN)) u_pc_slot (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sel_i (pc_sel),
    .d_i   (pc_i),
    .q_o   (pc_o)
  );

  fd_slot #(.WIDTH(XLEN)) u_ins_slot (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sel_i (ins_sel),
    .d_i   (instr_i),
    .q_o   (instr_o)
  );

  AST_STALL_PC_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |=> pc_o == '0); // R2
  AST_STALL_INS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |=> $stable(instr_o)); // R3
  AST_STALL_OVER_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_i && flush_i) |=> ($stable(instr_o) && pc_o == '0)); // R4
  AST_PC_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stall_i |=> pc_o == $past(pc_i)); // R5
  AST_FLUSH_BUBBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_i && flush_i) |=> instr_o == '0); // R6
  AST_NORMAL_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_i && !flush_i) |=> instr_o == $past(instr_i)); // R7
endmodule

// File: tb/fd_pipe_reg_bench.sv
`timescale 1ns/1ps
module fd_pipe_reg_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        stall_i = 1'b0;
  logic        flush_i = 1'b0;
  logic [31:0] pc_i = '0;
  logic [31:0] instr_i = '0;
  logic [31:0] pc_o;
  logic [31:0] instr_o;

  int n_chk = 0;
  int n_fail = 0;
  int n_step = 0;
  logic [31:0] exp_pc = '0;
  logic [31:0] exp_ins = '0;

  always #4 clk_i = ~clk_i;

  fd_pipe_reg u_fd_pipe_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .stall_i(stall_i),
    .flush_i(flush_i),
    .pc_i   (pc_i),
    .instr_i(instr_i),
    .pc_o   (pc_o),
    .instr_o(instr_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic step(input logic s, input logic f);
    logic [31:0] p, w;
    string rp, ri;
    p = 32'h0000_1000 + 32'(n_step) * 4;
    w = (32'(n_step) + 1) * 32'h9E37_79B1 ^ 32'h0000_0013;
    stall_i = s; flush_i = f; pc_i = p; instr_i = w;
    @(posedge clk_i);
    if (s) begin
      exp_pc = '0;
      rp = f ? "R4 pc zero on stall+flush" : "R2 pc zero on stall";
      ri = f ? "R4 instr held on stall+flush" : "R3 instr held on stall";
    end else begin
      exp_pc = p;
      rp = "R5 pc loads pc_i";
      if (f) begin exp_ins = '0; ri = "R6 flush bubble"; end
      else   begin exp_ins = w;  ri = "R7 normal capture"; end
    end
    @(negedge clk_i);
    check(rp, pc_o, exp_pc);
    check(ri, instr_o, exp_ins);
    n_step++;
  endtask

  initial begin
    #1;
    check("R1 reset pc", pc_o, 32'h0);
    check("R1 reset instr", instr_o, 32'h0);
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int c = 0; c < 4; c++) begin
          step(a[1], a[0]);
          step(b[1], b[0]);
          step(c[1], c[0]);
        end
    // long stall run
    step(1'b0, 1'b0);
    for (int k = 0; k < 5; k++) step(1'b1, k[0]);
    // mid-run reset with stall and flush high
    step(1'b0, 1'b0);
    stall_i = 1'b1; flush_i = 1'b1;
    #1 rst_ni = 1'b0;
    #1;
    check("R1 async reset pc", pc_o, 32'h0);
    check("R1 async reset instr", instr_o, 32'h0);
    @(posedge clk_i); @(negedge clk_i);
    check("R1 reset overrides stall pc", pc_o, 32'h0);
    check("R1 reset overrides stall instr", instr_o, 32'h0);
    rst_ni = 1'b1;
    exp_pc = '0; exp_ins = '0;
    step(1'b0, 1'b0);
    step(1'b0, 1'b1);
    step(1'b0, 1'b0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule